// File: doc/BRIEF.md
# Dual Time-Match Alarm with Interrupt Routing

This block watches a running calendar clock and raises an alarm when the time reaches a stored value. It holds two independent alarm units. Each unit compares four BCD-coded fields (seconds, minutes, hours, day of week) against the current time, once per one-second tick. Any field can be turned into a wildcard, so one alarm can fire every minute, every hour, every day or once a week.

When a unit matches, it latches a flag. When that unit's interrupt enable is set, the flag drives an active-low interrupt pin. A single routing bit chooses between two wirings. In the first, both alarms share one pin. In the second, each alarm has its own pin.

A register bus outside this block supplies the stored alarm bytes, the control bits and the strobes. A flag is cleared by a read strobe on that alarm's registers, or by a status write that carries a 0 in the flag's bit position. The time counter is also external and presents its current bytes together with a tick pulse after each update.

Top module: `dual_alarm_match`

## Requirements
- R1: After reset, both flags are 0 and both interrupt pins (`irq0_n`, `irq1_n`) are high.
- R2: Each alarm word packs four bytes: seconds in [7:0], minutes in [15:8], hours in [23:16] and day of week in [31:24]. On a cycle with `tick` high, an alarm's flag is 1 after the next rising edge when every field matches. A field matches when bits [6:0] of the alarm byte equal bits [6:0] of the current-time byte.
- R3: With `tick` low, a flag that is 0 stays 0, even when all fields match.
- R4: Bit 7 of an alarm byte set to 1 makes that field match any current value. This holds for each of the four fields and for any combination of them.
- R5: The hour field is compared on all of bits [6:0], including the 12-hour mode bit (bit 6) and the PM bit (bit 5). The same hour written in different formats therefore does not match.
- R6: A pulse on `alarm_rd[i]` clears flag i at the next rising edge and leaves the other flag unchanged.
- R7: A cycle with `stat_wr` high clears flag i when `stat_wdata[i]` is 0 and keeps it when `stat_wdata[i]` is 1.
- R8: When a match and a clear occur in the same cycle, the flag ends up set.
- R9: An alarm's interrupt request is its flag ANDed with its enable (`irq_en[i]`). The request pins are registered: a request asserts at the same edge that sets the flag, and it deasserts at the first edge after the flag or the enable drops.
- R10: With `route_split` = 0, `irq0_n` is low when either alarm requests, and `irq1_n` stays high.
- R11: With `route_split` = 1, `irq0_n` follows only alarm 0's request and `irq1_n` follows only alarm 1's request.
- R12: With no tick and no clear, a set flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse after each time update |
| cur_time | input | 32 | Current seconds, minutes, hours and day bytes |
| alarm0_cfg | input | 32 | Alarm 0 bytes; bit 7 of each byte is a wildcard |
| alarm1_cfg | input | 32 | Alarm 1 bytes; bit 7 of each byte is a wildcard |
| irq_en | input | 2 | Per-alarm interrupt enable |
| route_split | input | 1 | 0: shared pin; 1: separate pins |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Status write data; a 0 clears that flag |
| alarm_rd | input | 2 | Per-alarm register read strobe |
| flags | output | 2 | Alarm flags |
| irq0_n | output | 1 | Active-low interrupt, alarm 0 (or both alarms when shared) |
| irq1_n | output | 1 | Active-low interrupt, alarm 1 when split |

## Verification
The bench builds the block with its default 8-bit fields and four fields per alarm. With these values every one of the 16 wildcard masks can be crossed with every choice of mismatching field, including the case with no mismatching field. Alarm 1 is given the complementary mask in the same sweep, so both units are tested against opposite patterns at once. Directed sequences then cover the hour format bits, the two clear paths, the same-cycle set-versus-clear case, and both routing settings combined with enable changes.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;
  localparam int NUM_ALARMS = 2;
  localparam int NUM_FIELDS = 4;
  localparam int BYTE_W     = 8;

  typedef enum logic [1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DAY  = 2'd3
  } field_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] alm_byte,
  input  logic [W-1:0] cur_byte,
  output logic         hit
);
  localparam int DC = W - 1;

  // the top bit of the stored byte turns this field into a wildcard
  always_comb begin
    hit = alm_byte[DC] | (alm_byte[DC-1:0] == cur_byte[DC-1:0]);
  end
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit #(
  parameter int W  = 8,
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [NF*W-1:0] alm_bytes,
  input  logic [NF*W-1:0] cur_bytes,
  input  logic          clr,
  input  logic          en,
  output logic          flag,
  output logic          req_nxt
);
  logic [NF-1:0] fld_hit;
  logic          all_hit;
  logic          set_now;
  logic          flag_nxt;

  genvar g;
  generate
    for (g = 0; g < NF; g++) begin : g_fld
      alarm_field_cmp #(.W(W)) u_cmp (
        .alm_byte (alm_bytes[g*W +: W]),
        .cur_byte (cur_bytes[g*W +: W]),
        .hit      (fld_hit[g])
      );
    end
  endgenerate

  always_comb begin
    all_hit  = &fld_hit;
    set_now  = tick & all_hit;
    // a set in the same cycle overrides any clear
    flag_nxt = set_now | (flag & ~clr);
    req_nxt  = flag_nxt & en;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag_nxt;
  end

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (tick && all_hit) |=> flag); // R2
  AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !flag) |=> !flag); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr && !(tick && all_hit)) |=> !flag); // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr && flag) |=> flag); // R12
endmodule

// File: rtl/irq_router.sv
module irq_router (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req,
  input  logic       route_split,
  output logic       irq0_n,
  output logic       irq1_n
);
  logic line0, line1;

  always_comb begin
    if (route_split) begin
      line0 = req[0];
      line1 = req[1];
    end else begin
      line0 = req[0] | req[1];
      line1 = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0_n <= 1'b1;
      irq1_n <= 1'b1;
    end else begin
      irq0_n <= ~line0;
      irq1_n <= ~line1;
    end
  end

  AST_IRQ0_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req[0] |=> !irq0_n); // R9
  AST_SHARED_IRQ1_IDLE: assert property (@(posedge clk) disable iff (rst)
    !route_split |=> irq1_n); // R10
  AST_SPLIT_IRQ0_OWN: assert property (@(posedge clk) disable iff (rst)
    (route_split && !req[0]) |=> irq0_n); // R11
  AST_SPLIT_IRQ1_OWN: assert property (@(posedge clk) disable iff (rst)
    (route_split && req[1]) |=> !irq1_n); // R11
endmodule

// File: rtl/dual_alarm_match.sv
module dual_alarm_match
  import dual_alarm_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int NF = NUM_FIELDS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [NF*W-1:0] cur_time,
  input  logic [NF*W-1:0] alarm0_cfg,
  input  logic [NF*W-1:0] alarm1_cfg,
  input  logic [1:0]      irq_en,
  input  logic            route_split,
  input  logic            stat_wr,
  input  logic [1:0]      stat_wdata,
  input  logic [1:0]      alarm_rd,
  output logic [1:0]      flags,
  output logic            irq0_n,
  output logic            irq1_n
);
  localparam int WORD_W = NF * W;

  logic [WORD_W-1:0] cfg [NUM_ALARMS];
  logic [1:0] clr;
  logic [1:0] req_nxt;

  always_comb begin
    cfg[0] = alarm0_cfg;
    cfg[1] = alarm1_cfg;
  end

  genvar a;
  generate
    for (a = 0; a < NUM_ALARMS; a++) begin : g_alm
      always_comb clr[a] = alarm_rd[a] | (stat_wr & ~stat_wdata[a]);

      alarm_unit #(.W(W), .NF(NF)) u_unit (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .alm_bytes (cfg[a]),
        .cur_bytes (cur_time),
        .clr       (clr[a]),
        .en        (irq_en[a]),
        .flag      (flags[a]),
        .req_nxt   (req_nxt[a])
      );
    end
  endgenerate

  irq_router u_route (
    .clk         (clk),
    .rst         (rst),
    .req         (req_nxt),
    .route_split (route_split),
    .irq0_n      (irq0_n),
    .irq1_n      (irq1_n)
  );

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (alarm_rd[0] && !tick) |=> !flags[0]); // R6
  AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !stat_wdata[1] && !tick) |=> !flags[1]); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (tick && alarm_rd[0] && cur_time[6:0] == alarm0_cfg[6:0]
      && cur_time[14:8] == alarm0_cfg[14:8]
      && cur_time[22:16] == alarm0_cfg[22:16]
      && cur_time[30:24] == alarm0_cfg[30:24]) |=> flags[0]); // R8
  AST_IRQ_ENABLE_DROP: assert property (@(posedge clk) disable iff (rst)
    (route_split && !irq_en[1]) |=> irq1_n); // R9
endmodule

// File: tb/dual_alarm_match_tb.sv
module dual_alarm_match_tb;
  logic        clk = 0;
  logic        rst;
  logic        tick;
  logic [31:0] cur_time, alarm0_cfg, alarm1_cfg;
  logic [1:0]  irq_en;
  logic        route_split;
  logic        stat_wr;
  logic [1:0]  stat_wdata;
  logic [1:0]  alarm_rd;
  logic [1:0]  flags;
  logic        irq0_n, irq1_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  dual_alarm_match u_dut (
    .clk(clk), .rst(rst), .tick(tick), .cur_time(cur_time),
    .alarm0_cfg(alarm0_cfg), .alarm1_cfg(alarm1_cfg), .irq_en(irq_en),
    .route_split(route_split), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .alarm_rd(alarm_rd), .flags(flags), .irq0_n(irq0_n), .irq1_n(irq1_n)
  );

  localparam logic [31:0] BASE = 32'h05_23_30_45;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic clear_all();
    stat_wr = 1'b1; stat_wdata = 2'b00; step(); stat_wr = 1'b0; stat_wdata = 2'b11;
  endtask

  function automatic logic [31:0] with_mask(input logic [31:0] b, input logic [3:0] m);
    logic [31:0] r = b;
    for (int k = 0; k < 4; k++) r[k*8+7] = m[k];
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; tick = 0; cur_time = BASE; alarm0_cfg = BASE; alarm1_cfg = BASE;
    irq_en = 0; route_split = 0; stat_wr = 0; stat_wdata = 2'b11; alarm_rd = 0;
    step(); step(); rst = 0; step();
    check("R1 flags", {6'd0, flags}, 8'd0);
    check("R1 irq pins", {6'd0, irq1_n, irq0_n}, 8'h03);

    // R3: matching values without tick leave the flags clear
    step(); step();
    check("R3 no tick", {6'd0, flags}, 8'd0);

    // R2/R4 sweep: every wildcard mask against every mismatching field
    for (int m = 0; m < 16; m++) begin
      for (int f = 0; f < 5; f++) begin
        logic [31:0] cur;
        logic e0, e1;
        logic [3:0] m1;
        m1 = ~m[3:0];
        cur = BASE;
        if (f < 4) cur[f*8 +: 8] = cur[f*8 +: 8] ^ 8'h01;
        clear_all();
        cur_time = cur;
        alarm0_cfg = with_mask(BASE, m[3:0]);
        alarm1_cfg = with_mask(BASE, m1);
        e0 = (f == 4) || m[f];
        e1 = (f == 4) || m1[f];
        pulse_tick();
        check("R2/R4 alarm0", {7'd0, flags[0]}, {7'd0, e0});
        check("R2/R4 alarm1", {7'd0, flags[1]}, {7'd0, e1});
      end
    end

    // R5: hour 12 in three formats
    clear_all();
    cur_time = BASE; cur_time[23:16] = 8'h72;   // 12 PM, 12-hour mode
    alarm0_cfg = BASE; alarm0_cfg[23:16] = 8'h52; // 12 AM, 12-hour mode
    alarm1_cfg = BASE; alarm1_cfg[23:16] = 8'h72;
    pulse_tick();
    check("R5 12h AM vs PM", {7'd0, flags[0]}, 8'd0);
    check("R5 12h PM equal", {7'd0, flags[1]}, 8'd1);
    clear_all();
    alarm0_cfg[23:16] = 8'h12; // 24-hour 12
    pulse_tick();
    check("R5 24h vs 12h", {7'd0, flags[0]}, 8'd0);

    // set both flags
    cur_time = BASE; alarm0_cfg = BASE; alarm1_cfg = BASE;
    clear_all(); pulse_tick();
    check("R2 both set", {6'd0, flags}, 8'h03);
    step(); step();
    check("R12 hold", {6'd0, flags}, 8'h03);

    alarm_rd = 2'b01; step(); alarm_rd = 0;
    check("R6 read clears alarm0 only", {6'd0, flags}, 8'h02);
    pulse_tick();
    stat_wr = 1; stat_wdata = 2'b01; step(); stat_wr = 0; stat_wdata = 2'b11;
    check("R7 status write", {6'd0, flags}, 8'h01);

    // R8 set wins over read clear
    clear_all();
    alarm_rd = 2'b11; tick = 1; step(); tick = 0; alarm_rd = 0;
    check("R8 set wins", {6'd0, flags}, 8'h03);

    // R9/R10 shared routing
    clear_all();
    route_split = 0; irq_en = 2'b10;
    step();
    check("R9 no flag no irq", {6'd0, irq1_n, irq0_n}, 8'h03);
    alarm1_cfg = with_mask(BASE, 4'h0); alarm0_cfg = BASE ^ 32'h1;
    pulse_tick();
    check("R10 shared alarm1 on irq0", {6'd0, irq1_n, irq0_n}, 8'h02);
    // R11 split routing
    route_split = 1; step();
    check("R11 split", {6'd0, irq1_n, irq0_n}, 8'h01);
    irq_en = 2'b00; step();
    check("R9 enable drop", {6'd0, irq1_n, irq0_n}, 8'h03);
    irq_en = 2'b11; alarm0_cfg = BASE; pulse_tick();
    check("R11 split both", {6'd0, irq1_n, irq0_n}, 8'h00);
    alarm_rd = 2'b01; step(); alarm_rd = 0;
    check("R9 read drops irq0", {6'd0, irq1_n, irq0_n}, 8'h01);
    route_split = 0; step();
    check("R10 shared after split", {6'd0, irq1_n, irq0_n}, 8'h02);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule